// File: doc/BRIEF.md
# Stoppable Synchronous Card Clock Generator

This block produces the serial clock for a card interface that runs in synchronous mode. A half-period counter divides the system clock by a programmable value. Each terminal count toggles a registered card clock, so the output has a 50% duty cycle and cannot glitch. Downstream shift logic gets single-cycle strobes that mark every rising and every falling edge of the card clock. It also gets a qualifier that flags the one falling edge that is not a real data edge.

Software stops the clock with a clock-off control and chooses the level the clock rests at. A stop never cuts a phase short. If the clock is at the other level when the stop arrives, the current phase runs to its full length and the clock then rests at the chosen level. If the clock is already at the chosen level, it simply stays there. A restart follows one of two fixed sequences, depending on where the clock rested. The clock runs only while its interface is selected: deselecting the interface stops the clock in the same way as clock-off.

Top module: `sync_card_clk`

## Requirements
- R1: While running, every high phase and every low phase of `card_clk` lasts exactly E system cycles. E is the effective divisor: E equals `divisor`, except that 0 gives E = 1.
- R2: A `divisor` of 0 gives the same behaviour as a `divisor` of 1, which is a card clock toggling every system cycle.
- R3: `rise_stb` is high for exactly the first system cycle in which `card_clk` is 1 after being 0. `fall_stb` is high for exactly the first cycle in which `card_clk` is 0 after being 1. The two strobes are never high together, and `card_clk` never changes without one of them.
- R4: A stop request (`clk_off` = 1 or `if_sel` = 0) while `card_clk` differs from the rest level lets the current phase complete its full E cycles. `card_clk` then changes to the rest level and stays there. The rest level is 1 when `park_high` = 1 and 0 when `park_high` = 0.
- R5: A stop request while `card_clk` already equals the rest level keeps `card_clk` at that level, and no strobe is produced.
- R6: A restart from a low rest keeps `card_clk` low for E cycles after the first clock edge that sees the run condition (`if_sel` = 1 and `clk_off` = 0). The clock then rises, and `start_high_flag` stays 0.
- R7: A restart from a high rest drives `card_clk` low on the first clock edge that sees the run condition. That edge raises `fall_stb` together with `start_high_flag` for that single cycle. A low phase of E cycles follows.
- R8: While `if_sel` = 0, the clock stops as in R4/R5 and stays at rest whatever `clk_off` does.
- R9: Reset leaves `card_clk`, both strobes and `start_high_flag` at 0, with the clock at rest low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | DIV_W | Half-period length in system cycles (0 acts as 1) |
| clk_off | input | 1 | 1 requests a stop; clearing it starts the clock |
| park_high | input | 1 | Rest level for a stop: 1 high, 0 low |
| if_sel | input | 1 | Interface selected; 0 stops the clock |
| card_clk | output | 1 | Registered card clock |
| rise_stb | output | 1 | One-cycle strobe on each card clock rise |
| fall_stb | output | 1 | One-cycle strobe on each card clock fall |
| start_high_flag | output | 1 | Marks the immediate fall of a restart from a high rest |

## Verification
The bench sweeps divisor values 0 to 5 against both rest levels. It measures every gap between clock changes in system cycles and compares each gap with the effective divisor, which the bench computes itself. A divisor-0 design that divides by 0 or by 256 would show a wrong gap at the first change. A stop that truncated a phase would shorten the gap before the rest. Stopping at the rest level must produce no edge, and a design that toggled once more would show a stray strobe. On a restart from high the clock must fall on the very next edge and raise the qualifier for exactly one cycle. A restart from low must hold low for a full half-period first. A design that swapped the two sequences would fail both checks. A deselected interface must stay at rest even with clock-off cleared.

// File: rtl/sccg_pkg.sv
package sccg_pkg;

  typedef enum logic {
    ST_PARK = 1'b0,
    ST_RUN  = 1'b1
  } sccg_state_e;

  // Effective half-period length: zero is promoted to one.
  function automatic logic [31:0] eff_half(input logic [31:0] div);
    return (div == 32'd0) ? 32'd1 : div;
  endfunction

endpackage

// File: rtl/sccg_divider.sv
module sccg_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             half_done
);
  logic [DIV_W-1:0] cnt;
  logic [31:0]      eff_w;
  logic [31:0]      cnt_w;

  assign eff_w     = sccg_pkg::eff_half(32'(divisor));
  assign cnt_w     = 32'(cnt);
  // >= guards against a divisor lowered mid-phase
  assign half_done = run && ((cnt_w + 32'd1) >= eff_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || half_done) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sccg_ctrl.sv
module sccg_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic run_req,
  input  logic park_high,
  input  logic card_lvl,
  input  logic half_done,
  output logic start_ev,
  output logic force_low,
  output logic toggle,
  output logic running,
  output logic parked
);
  import sccg_pkg::*;

  sccg_state_e state, nxt;

  always_comb begin
    nxt       = state;
    start_ev  = 1'b0;
    force_low = 1'b0;
    toggle    = 1'b0;
    case (state)
      ST_PARK: begin
        if (run_req) begin
          start_ev  = 1'b1;
          force_low = card_lvl;
          nxt       = ST_RUN;
        end
      end
      ST_RUN: begin
        if (!run_req && (card_lvl == park_high)) begin
          nxt = ST_PARK;
        end else if (half_done) begin
          toggle = 1'b1;
          if (!run_req) nxt = ST_PARK;
        end
      end
      default: nxt = ST_PARK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_PARK;
    else        state <= nxt;
  end

  assign running = (state == ST_RUN);
  assign parked  = (state == ST_PARK);
endmodule

// File: rtl/sccg_out.sv
module sccg_out (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle,
  input  logic force_low,
  output logic card_clk,
  output logic rise_stb,
  output logic fall_stb,
  output logic start_high_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      card_clk        <= 1'b0;
      rise_stb        <= 1'b0;
      fall_stb        <= 1'b0;
      start_high_flag <= 1'b0;
    end else begin
      if (force_low)   card_clk <= 1'b0;
      else if (toggle) card_clk <= ~card_clk;
      rise_stb        <= toggle && !force_low && !card_clk;
      fall_stb        <= force_low || (toggle && card_clk);
      start_high_flag <= force_low;
    end
  end
endmodule

// File: rtl/sync_card_clk.sv
module sync_card_clk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             clk_off,
  input  logic             park_high,
  input  logic             if_sel,
  output logic             card_clk,
  output logic             rise_stb,
  output logic             fall_stb,
  output logic             start_high_flag
);
  // named internal events
  logic run_req;
  logic half_done;
  logic ev_start;
  logic ev_force_low;
  logic ev_toggle;
  logic running;
  logic parked;

  assign run_req = if_sel && !clk_off;

  sccg_divider #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (ev_start),
    .run       (running),
    .divisor   (divisor),
    .half_done (half_done)
  );

  sccg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_req   (run_req),
    .park_high (park_high),
    .card_lvl  (card_clk),
    .half_done (half_done),
    .start_ev  (ev_start),
    .force_low (ev_force_low),
    .toggle    (ev_toggle),
    .running   (running),
    .parked    (parked)
  );

  sccg_out u_out (
    .clk             (clk),
    .rst_n           (rst_n),
    .toggle          (ev_toggle),
    .force_low       (ev_force_low),
    .card_clk        (card_clk),
    .rise_stb        (rise_stb),
    .fall_stb        (fall_stb),
    .start_high_flag (start_high_flag)
  );
endmodule

// File: rtl/sync_card_clk_checker.sv
module sync_card_clk_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] divisor,
  input logic             clk_off,
  input logic             park_high,
  input logic             if_sel,
  input logic             card_clk,
  input logic             rise_stb,
  input logic             fall_stb,
  input logic             start_high_flag,
  input logic             parked
);
  logic             run_req_c;
  logic             strobe;
  logic [15:0]      ph_cnt;
  logic             park_seen;
  logic             div_dirty;
  logic [DIV_W-1:0] div_q;

  assign run_req_c = if_sel && !clk_off;
  assign strobe    = rise_stb || fall_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_cnt    <= '0;
      park_seen <= 1'b1;
      div_dirty <= 1'b1;
      div_q     <= '0;
    end else begin
      div_q <= divisor;
      if (strobe) begin
        ph_cnt    <= 16'd1;
        park_seen <= parked;
        div_dirty <= (divisor != div_q);
      end else begin
        if (ph_cnt != 16'hFFFF) ph_cnt <= ph_cnt + 16'd1;
        park_seen <= park_seen || parked;
        div_dirty <= div_dirty || (divisor != div_q);
      end
    end
  end

  // R1 / R2: free-running phase length equals effective divisor
  p_phase_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_stb || (fall_stb && !start_high_flag)) && !park_seen && !div_dirty
      && (divisor == div_q))
    |-> (32'(ph_cnt) == sccg_pkg::eff_half(32'(divisor))));

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));

  p_rise_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (card_clk && !$past(card_clk)));

  p_fall_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (!card_clk && $past(card_clk)));

  p_change_strobed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (card_clk != $past(card_clk)) |-> strobe);

  p_park_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(parked) |-> (card_clk == $past(park_high)));

  p_flag_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_high_flag |-> fall_stb);

  p_flag_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_high_flag |=> !start_high_flag);

  p_hold_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (parked && !run_req_c) |=> $stable(card_clk));
endmodule

bind sync_card_clk sync_card_clk_checker #(.DIV_W(DIV_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .divisor         (divisor),
  .clk_off         (clk_off),
  .park_high       (park_high),
  .if_sel          (if_sel),
  .card_clk        (card_clk),
  .rise_stb        (rise_stb),
  .fall_stb        (fall_stb),
  .start_high_flag (start_high_flag),
  .parked          (parked)
);

// File: tb/sync_card_clk_tb.sv
`timescale 1ns/1ps
module sync_card_clk_tb;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [DIV_W-1:0] divisor;
  logic             clk_off;
  logic             park_high;
  logic             if_sel;
  logic             card_clk;
  logic             rise_stb;
  logic             fall_stb;
  logic             start_high_flag;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  sync_card_clk #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .clk_off(clk_off),
    .park_high(park_high), .if_sel(if_sel), .card_clk(card_clk),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .start_high_flag(start_high_flag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // counts negedge samples until card_clk changes
  task automatic gap(output int n, output logic lvl, output int flags);
    logic p;
    p = card_clk;
    n = 0;
    flags = 0;
    do begin
      @(negedge clk);
      n++;
      if (start_high_flag) flags++;
    end while (card_clk == p && n < 1000);
    lvl = card_clk;
  endtask

  task automatic check_edge(input string tag, input int n, input logic lvl,
                            input int exp_n, input logic exp_lvl);
    chk(n == exp_n, {tag, " gap"}, n, exp_n);
    chk(lvl == exp_lvl, {tag, " level"}, int'(lvl), int'(exp_lvl));
    chk(rise_stb == exp_lvl && fall_stb == !exp_lvl, {"R3 strobe ", tag},
        int'({rise_stb, fall_stb}), int'({exp_lvl, !exp_lvl}));
  endtask

  task automatic hold(input int cyc, input logic lvl, input string tag);
    int bad = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (card_clk != lvl || rise_stb || fall_stb) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  function automatic int eff(input int d);
    return (d < 1) ? 1 : d;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  initial begin
    int n;
    int fl;
    logic lv;
    int e;
    rst_n = 1'b0; divisor = 8'd3; clk_off = 1'b1; park_high = 1'b0; if_sel = 1'b1;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk({card_clk, rise_stb, fall_stb, start_high_flag} == 4'b0, "R9 reset outputs",
        int'({card_clk, rise_stb, fall_stb, start_high_flag}), 0);
    rst_n = 1'b1;
    hold(4, 1'b0, "R9 rest low after reset");

    for (int d = 0; d <= 5; d++) begin
      for (int pk = 0; pk < 2; pk++) begin
        e = eff(d);
        @(negedge clk);
        clk_off = 1'b1; park_high = 1'b0; if_sel = 1'b1; divisor = DIV_W'(d);
        hold(2 * e + 4, 1'b0, "R8 idle rest low");

        // R6: restart from low rest
        clk_off = 1'b0;
        gap(n, lv, fl);
        check_edge("R6 low restart", n, lv, e + 1, 1'b1);
        chk(fl == 0, "R6 no start flag", fl, 0);
        // R1 / R2: free running phases
        gap(n, lv, fl);
        check_edge(d == 0 ? "R2 div0 fall" : "R1 fall", n, lv, e, 1'b0);
        gap(n, lv, fl);
        check_edge(d == 0 ? "R2 div0 rise" : "R1 rise", n, lv, e, 1'b1);

        if (pk == 0) begin
          // R4: stop mid high phase, rest low
          if (e >= 2) @(negedge clk);
          park_high = 1'b0; clk_off = 1'b1;
          gap(n, lv, fl);
          check_edge("R4 stop completes phase", n, lv, (e >= 2) ? e - 1 : e, 1'b0);
          hold(2 * e + 3, 1'b0, "R4 stays at rest low");
          clk_off = 1'b0;
          gap(n, lv, fl);
          check_edge("R6 restart again", n, lv, e + 1, 1'b1);
        end else begin
          // R5: stop while already at rest level high
          park_high = 1'b1; clk_off = 1'b1;
          hold(2 * e + 3, 1'b1, "R5 hold at rest high");
          // R7: restart from high rest
          clk_off = 1'b0;
          gap(n, lv, fl);
          check_edge("R7 immediate fall", n, lv, 1, 1'b0);
          chk(start_high_flag == 1'b1 && fl == 1, "R7 start flag", fl, 1);
          gap(n, lv, fl);
          check_edge("R7 low after start", n, lv, e, 1'b1);
          chk(fl == 0, "R7 flag cleared", fl, 0);
        end

        // R8: deselect stops clock even with clk_off cleared
        park_high = 1'b0; if_sel = 1'b0;
        gap(n, lv, fl);
        check_edge("R8 deselect stop", n, lv, e, 1'b0);
        hold(2 * e + 3, 1'b0, "R8 deselected stays at rest");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule